// File: doc/BRIEF.md
# Pre-adder multiply-accumulate slice

This block is a pipelined signed arithmetic slice with three stages. First an optional 25-bit pre-adder adds a registered D operand to the low 25 bits of the registered A operand. The result then drives a signed 25 x 18 multiplier together with a twice-registered B operand. Last comes a 48-bit three-operand adder. Each of that adder's operands comes from its own multiplexer, and a 7-bit opcode drives all three selects. The sources on offer are zero, the sign-extended product, the P feedback, the 48-bit {A,B} concatenation, all-ones, the registered C operand, an external cascade input and 17-bit arithmetic right shifts of the cascade input and of P. A 3-bit carry select picks the carry into that adder.

One datapath can therefore multiply, accumulate, add wide words built from {A,B} and C, round with a sign-dependent carry, or add a shifted partial result to build a wider multiplication. Every register group has its own clock enable and synchronous reset, and reset takes priority. A parameter turns each group into a plain wire instead.

Top module: `premac_slice`

## Requirements
- R1: With every stage enabled and the default parameters, a value on a, b and d first shows in p exactly 4 rising edges after it is applied (opcode X=product). Before that edge, p still shows the previous contents of the pipeline.
- R2: The pre-adder forms (a[24:0] + d) modulo 2^25 as a signed 25-bit value. The multiplier takes that value times signed b, and the 43-bit product is sign-extended to 48 bits.
- R3: Opcode bits [1:0] select X: 0 gives zero, 1 the product, 2 the P feedback, 3 the concatenation {a,b} (a in bits 47:18), delayed like the product.
- R4: Opcode bits [3:2] select Y: 0 and 1 give zero (1 is the product partner, which is zero because the product is complete), 2 gives all-ones, 3 gives the registered C.
- R5: Opcode bits [6:4] select Z: 0 zero, 1 pcin, 2 P, 3 registered C, 4 pcin arithmetically shifted right by 17, 5 P arithmetically shifted right by 17, 6 and 7 zero.
- R6: carry_sel picks the carry into the final adder: 0 carry_in, 1 bit 47 of P, 2 inverted bit 47 of P, 3 sign of the registered product, 4 inverted sign of the registered product, 5 to 7 zero.
- R7: On an enabled edge, P takes X + Y + Z + carry modulo 2^48.
- R8: c passes through its own register. It reaches p through Y or Z 2 edges after it is applied, and that register has its own enable ce_c and reset rst_c.
- R9: While a group's enable is low and its reset is low, that group keeps its value. For P, p stays unchanged.
- R10: A synchronous reset clears its register group to zero on the next edge even when the group's enable is high.
- R11: pcin, opmode, carry_sel and carry_in go to the final adder without a register and act on the edge at which P captures.
- R12: Under random data, opcodes, enables and occasional resets, p matches a cycle-by-cycle arithmetic model of the stages above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_in | input | 1 | Synchronous reset of the A, B and D input registers |
| ce_in | input | 1 | Enable of the A, B and D input registers |
| rst_c | input | 1 | Synchronous reset of the C register |
| ce_c | input | 1 | Enable of the C register |
| rst_mid | input | 1 | Synchronous reset of the pre-adder, second A and second B registers |
| ce_mid | input | 1 | Enable of the pre-adder, second A and second B registers |
| rst_m | input | 1 | Synchronous reset of the product and {A,B} registers |
| ce_m | input | 1 | Enable of the product and {A,B} registers |
| rst_p | input | 1 | Synchronous reset of the P register |
| ce_p | input | 1 | Enable of the P register |
| a | input | 30 | A operand; low 25 bits to the pre-adder, all bits to {A,B} |
| b | input | 18 | Signed B operand |
| c | input | 48 | C operand |
| d | input | 25 | D operand of the pre-adder |
| pcin | input | 48 | Cascade input to the Z multiplexer |
| opmode | input | 7 | Operand selects: [1:0] X, [3:2] Y, [6:4] Z |
| carry_sel | input | 3 | Carry source select |
| carry_in | input | 1 | External carry bit |
| p | output | 48 | Registered result |

## Verification
A wrong value in any stage register reaches p through the product or {A,B} path within at most 3 edges, and through the C path within 1 edge. With P feedback selected, a corrupted P keeps showing up in every later result until P is reset. The sign-dependent carry codes expose a wrong P bit 47 or a wrong product sign on the next edge as an off-by-one. A held stage that wrongly updates shows up as p drifting away from the arithmetic model on the edge the stale value would have reached P.

// File: rtl/premac_pkg.sv
`timescale 1ns/1ps
package premac_pkg;

    // X operand source, opcode bits [1:0]
    typedef enum logic [1:0] {
        XS_ZERO = 2'd0,
        XS_PROD = 2'd1,
        XS_PFB  = 2'd2,
        XS_CAT  = 2'd3
    } xsel_e;

    // Y operand source, opcode bits [3:2]
    typedef enum logic [1:0] {
        YS_ZERO    = 2'd0,
        YS_PARTNER = 2'd1,
        YS_ONES    = 2'd2,
        YS_C       = 2'd3
    } ysel_e;

    // Z operand source, opcode bits [6:4]
    typedef enum logic [2:0] {
        ZS_ZERO    = 3'd0,
        ZS_PCIN    = 3'd1,
        ZS_PFB     = 3'd2,
        ZS_C       = 3'd3,
        ZS_PCIN_SH = 3'd4,
        ZS_PFB_SH  = 3'd5,
        ZS_RSV6    = 3'd6,
        ZS_RSV7    = 3'd7
    } zsel_e;

    // carry source select
    typedef enum logic [2:0] {
        CS_PORT    = 3'd0,
        CS_PSIGN   = 3'd1,
        CS_PSIGN_N = 3'd2,
        CS_MSIGN   = 3'd3,
        CS_MSIGN_N = 3'd4,
        CS_RSV5    = 3'd5,
        CS_RSV6    = 3'd6,
        CS_RSV7    = 3'd7
    } csel_e;

    typedef struct packed {
        zsel_e z;
        ysel_e y;
        xsel_e x;
    } opcode_t;

endpackage

// File: rtl/premac_pipe_reg.sv
`timescale 1ns/1ps
// One register group of the slice: synchronous reset over enable, or a wire.
module premac_pipe_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (EN) begin : g_reg
            typedef struct packed {
                logic [W-1:0] val;
            } grp_t;

            grp_t grp_d, grp_q;

            always_comb begin
                grp_d = grp_q;
                if (rst) begin
                    grp_d.val = '0;
                end else if (ce) begin
                    grp_d.val = din;
                end
            end

            always_ff @(posedge clk) begin
                grp_q <= grp_d;
            end

            assign dout = grp_q.val;
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, ce};
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/premac_preadd.sv
`timescale 1ns/1ps
// Pre-adder ahead of the multiplier; result wraps at MA_W bits.
module premac_preadd #(
    parameter int MA_W       = 25,
    parameter int D_W        = 25,
    parameter bit USE_PREADD = 1'b1
) (
    input  logic [MA_W-1:0] a_low,
    input  logic [D_W-1:0]  d_in,
    output logic [MA_W-1:0] ad
);

    generate
        if (USE_PREADD) begin : g_add
            logic [MA_W-1:0] d_fit;
            assign d_fit = MA_W'(d_in);
            always_comb begin
                ad = a_low + d_fit;
            end
        end else begin : g_pass
            logic unused_d;
            assign unused_d = ^d_in;
            always_comb begin
                ad = a_low;
            end
        end
    endgenerate

endmodule

// File: rtl/premac_mult.sv
`timescale 1ns/1ps
// Signed MA_W x B_W multiplier, full-width product.
module premac_mult #(
    parameter int MA_W = 25,
    parameter int B_W  = 18,
    localparam int PROD_W = MA_W + B_W
) (
    input  logic [MA_W-1:0]   ad,
    input  logic [B_W-1:0]    b_op,
    output logic [PROD_W-1:0] prod
);

    logic signed [PROD_W-1:0] prod_s;

    always_comb begin
        prod_s = $signed(ad) * $signed(b_op);
        prod   = prod_s;
    end

endmodule

// File: rtl/premac_final_alu.sv
`timescale 1ns/1ps
// Three opcode-selected operands plus a selected carry, added at P_W bits.
module premac_final_alu
    import premac_pkg::*;
#(
    parameter int P_W    = 48,
    parameter int PROD_W = 43,
    parameter int AB_W   = 48,
    parameter int SHIFT  = 17
) (
    input  logic [PROD_W-1:0] prod,
    input  logic [AB_W-1:0]   ab,
    input  logic [P_W-1:0]    c_op,
    input  logic [P_W-1:0]    p_fb,
    input  logic [P_W-1:0]    pcin,
    input  logic [6:0]        opmode,
    input  logic [2:0]        carry_sel,
    input  logic              carry_in,
    output logic [P_W-1:0]    sum
);

    typedef struct packed {
        logic [P_W-1:0] x;
        logic [P_W-1:0] y;
        logic [P_W-1:0] z;
        logic           cin;
    } operands_t;

    opcode_t        op;
    operands_t      opd;
    logic [P_W-1:0] prod_ext;
    logic [P_W-1:0] pcin_sh;
    logic [P_W-1:0] pfb_sh;

    assign op       = opcode_t'(opmode);
    assign prod_ext = P_W'($signed(prod));
    assign pcin_sh  = $signed(pcin) >>> SHIFT;
    assign pfb_sh   = $signed(p_fb) >>> SHIFT;

    always_comb begin
        opd = '0;

        unique case (op.x)
            XS_ZERO: opd.x = '0;
            XS_PROD: opd.x = prod_ext;
            XS_PFB:  opd.x = p_fb;
            XS_CAT:  opd.x = P_W'(ab);
            default: opd.x = '0;
        endcase

        // the product leaves the multiplier complete, so its partner is zero
        unique case (op.y)
            YS_ZERO:    opd.y = '0;
            YS_PARTNER: opd.y = '0;
            YS_ONES:    opd.y = '1;
            YS_C:       opd.y = c_op;
            default:    opd.y = '0;
        endcase

        unique case (op.z)
            ZS_PCIN:    opd.z = pcin;
            ZS_PFB:     opd.z = p_fb;
            ZS_C:       opd.z = c_op;
            ZS_PCIN_SH: opd.z = pcin_sh;
            ZS_PFB_SH:  opd.z = pfb_sh;
            default:    opd.z = '0;
        endcase

        unique case (csel_e'(carry_sel))
            CS_PORT:    opd.cin = carry_in;
            CS_PSIGN:   opd.cin = p_fb[P_W-1];
            CS_PSIGN_N: opd.cin = ~p_fb[P_W-1];
            CS_MSIGN:   opd.cin = prod[PROD_W-1];
            CS_MSIGN_N: opd.cin = ~prod[PROD_W-1];
            default:    opd.cin = 1'b0;
        endcase

        sum = opd.x + opd.y + opd.z + P_W'(opd.cin);
    end

endmodule

// File: rtl/premac_slice.sv
`timescale 1ns/1ps
// Pipelined pre-adder / multiplier / three-operand adder slice.
// P feedback needs P_REG = 1; with P_REG = 0 the feedback codes form a loop.
module premac_slice #(
    parameter int A_W        = 30,
    parameter int B_W        = 18,
    parameter int D_W        = 25,
    parameter int P_W        = 48,
    parameter int MA_W       = 25,
    parameter int SHIFT      = 17,
    parameter bit USE_PREADD = 1'b1,
    parameter bit IN_REG     = 1'b1,
    parameter bit C_REG      = 1'b1,
    parameter bit MID_REG    = 1'b1,
    parameter bit M_REG      = 1'b1,
    parameter bit P_REG      = 1'b1
) (
    input  logic           clk,
    input  logic           rst_in,
    input  logic           ce_in,
    input  logic           rst_c,
    input  logic           ce_c,
    input  logic           rst_mid,
    input  logic           ce_mid,
    input  logic           rst_m,
    input  logic           ce_m,
    input  logic           rst_p,
    input  logic           ce_p,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    input  logic [P_W-1:0] c,
    input  logic [D_W-1:0] d,
    input  logic [P_W-1:0] pcin,
    input  logic [6:0]     opmode,
    input  logic [2:0]     carry_sel,
    input  logic           carry_in,
    output logic [P_W-1:0] p
);

    localparam int PROD_W = MA_W + B_W;
    localparam int AB_W   = A_W + B_W;

    // input stage
    logic [A_W-1:0]    a1;
    logic [B_W-1:0]    b1;
    logic [D_W-1:0]    d1;
    logic [P_W-1:0]    c1;
    // pre-adder stage
    logic [MA_W-1:0]   ad_sum;
    logic [MA_W-1:0]   ad2;
    logic [A_W-1:0]    a2;
    logic [B_W-1:0]    b2;
    // multiplier stage
    logic [PROD_W-1:0] prod_c;
    logic [PROD_W-1:0] prod3;
    logic [AB_W-1:0]   ab3;
    // output stage
    logic [P_W-1:0]    p_next;
    logic [P_W-1:0]    p_q;

    premac_pipe_reg #(.W(A_W), .EN(IN_REG)) u_a1 (
        .clk(clk), .rst(rst_in), .ce(ce_in), .din(a), .dout(a1)
    );
    premac_pipe_reg #(.W(B_W), .EN(IN_REG)) u_b1 (
        .clk(clk), .rst(rst_in), .ce(ce_in), .din(b), .dout(b1)
    );
    premac_pipe_reg #(.W(D_W), .EN(IN_REG)) u_d1 (
        .clk(clk), .rst(rst_in), .ce(ce_in), .din(d), .dout(d1)
    );
    premac_pipe_reg #(.W(P_W), .EN(C_REG)) u_c1 (
        .clk(clk), .rst(rst_c), .ce(ce_c), .din(c), .dout(c1)
    );

    premac_preadd #(.MA_W(MA_W), .D_W(D_W), .USE_PREADD(USE_PREADD)) u_preadd (
        .a_low(a1[MA_W-1:0]), .d_in(d1), .ad(ad_sum)
    );

    premac_pipe_reg #(.W(MA_W), .EN(MID_REG)) u_ad2 (
        .clk(clk), .rst(rst_mid), .ce(ce_mid), .din(ad_sum), .dout(ad2)
    );
    premac_pipe_reg #(.W(A_W), .EN(MID_REG)) u_a2 (
        .clk(clk), .rst(rst_mid), .ce(ce_mid), .din(a1), .dout(a2)
    );
    premac_pipe_reg #(.W(B_W), .EN(MID_REG)) u_b2 (
        .clk(clk), .rst(rst_mid), .ce(ce_mid), .din(b1), .dout(b2)
    );

    premac_mult #(.MA_W(MA_W), .B_W(B_W)) u_mult (
        .ad(ad2), .b_op(b2), .prod(prod_c)
    );

    premac_pipe_reg #(.W(PROD_W), .EN(M_REG)) u_m3 (
        .clk(clk), .rst(rst_m), .ce(ce_m), .din(prod_c), .dout(prod3)
    );
    premac_pipe_reg #(.W(AB_W), .EN(M_REG)) u_ab3 (
        .clk(clk), .rst(rst_m), .ce(ce_m), .din({a2, b2}), .dout(ab3)
    );

    premac_final_alu #(
        .P_W(P_W), .PROD_W(PROD_W), .AB_W(AB_W), .SHIFT(SHIFT)
    ) u_alu (
        .prod(prod3), .ab(ab3), .c_op(c1), .p_fb(p_q), .pcin(pcin),
        .opmode(opmode), .carry_sel(carry_sel), .carry_in(carry_in),
        .sum(p_next)
    );

    premac_pipe_reg #(.W(P_W), .EN(P_REG)) u_p (
        .clk(clk), .rst(rst_p), .ce(ce_p), .din(p_next), .dout(p_q)
    );

    assign p = p_q;

endmodule

// File: rtl/premac_slice_chk.sv
`timescale 1ns/1ps
// Port-level properties of the output stage.
module premac_slice_chk #(
    parameter int P_W = 48
) (
    input logic           clk,
    input logic           rst_p,
    input logic           ce_p,
    input logic [6:0]     opmode,
    input logic [2:0]     carry_sel,
    input logic           carry_in,
    input logic [P_W-1:0] pcin,
    input logic [P_W-1:0] p
);

    // R10: reset clears P even with the enable high
    p_rst_clear_r10: assert property (@(posedge clk)
        rst_p |=> (p == '0));

    // R9: P holds while its enable is low
    p_hold_r9: assert property (@(posedge clk) disable iff (rst_p)
        !ce_p |=> $stable(p));

    // R7: Z=P with the port carry set adds exactly one
    p_accum_r7: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && opmode == 7'b0100000 && carry_sel == 3'd0 && carry_in)
        |=> (p == $past(p) + 1'b1));

    // R5: Z=pcin alone passes the cascade input through
    p_pcin_pass_r5: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && opmode == 7'b0010000 && carry_sel == 3'd0 && !carry_in)
        |=> (p == $past(pcin)));

    // R4: Y=all-ones alone gives all-ones
    p_ones_r4: assert property (@(posedge clk) disable iff (rst_p)
        (ce_p && opmode == 7'b0001000 && carry_sel == 3'd0 && !carry_in)
        |=> (p == '1));

endmodule

bind premac_slice premac_slice_chk #(.P_W(P_W)) u_chk (
    .clk(clk), .rst_p(rst_p), .ce_p(ce_p), .opmode(opmode),
    .carry_sel(carry_sel), .carry_in(carry_in), .pcin(pcin), .p(p)
);

// File: tb/premac_slice_test.sv
`timescale 1ns/1ps
module premac_slice_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_in, ce_in, rst_c, ce_c, rst_mid, ce_mid, rst_m, ce_m, rst_p, ce_p;
    logic [29:0] a;
    logic [17:0] b;
    logic [47:0] c;
    logic [24:0] d;
    logic [47:0] pcin;
    logic [6:0]  opmode;
    logic [2:0]  carry_sel;
    logic        carry_in;
    logic [47:0] p;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    premac_slice uut (
        .clk(clk), .rst_in(rst_in), .ce_in(ce_in), .rst_c(rst_c), .ce_c(ce_c),
        .rst_mid(rst_mid), .ce_mid(ce_mid), .rst_m(rst_m), .ce_m(ce_m),
        .rst_p(rst_p), .ce_p(ce_p), .a(a), .b(b), .c(c), .d(d), .pcin(pcin),
        .opmode(opmode), .carry_sel(carry_sel), .carry_in(carry_in), .p(p)
    );

    // arithmetic model of the stages
    logic [29:0] m_a1, m_a2;
    logic [17:0] m_b1, m_b2;
    logic [24:0] m_d, m_ad;
    logic [47:0] m_c, m_m, m_ab, m_p;

    function automatic logic [47:0] model_sum();
        logic [47:0] xv, yv, zv;
        logic        cin;
        case (opmode[1:0])
            2'd1:    xv = m_m;
            2'd2:    xv = m_p;
            2'd3:    xv = m_ab;
            default: xv = '0;
        endcase
        case (opmode[3:2])
            2'd2:    yv = '1;
            2'd3:    yv = m_c;
            default: yv = '0;
        endcase
        case (opmode[6:4])
            3'd1:    zv = pcin;
            3'd2:    zv = m_p;
            3'd3:    zv = m_c;
            3'd4:    zv = $signed(pcin) >>> 17;
            3'd5:    zv = $signed(m_p) >>> 17;
            default: zv = '0;
        endcase
        case (carry_sel)
            3'd0:    cin = carry_in;
            3'd1:    cin = m_p[47];
            3'd2:    cin = ~m_p[47];
            3'd3:    cin = m_m[47];
            3'd4:    cin = ~m_m[47];
            default: cin = 1'b0;
        endcase
        return xv + yv + zv + {47'd0, cin};
    endfunction

    task automatic tick();
        logic signed [47:0] pr;
        logic [47:0]        np;
        @(posedge clk);
        np = model_sum();
        pr = $signed(m_ad) * $signed(m_b2);
        if (rst_p) m_p = '0; else if (ce_p) m_p = np;
        if (rst_m) begin m_m = '0; m_ab = '0; end
        else if (ce_m) begin m_m = pr; m_ab = {m_a2, m_b2}; end
        if (rst_mid) begin m_ad = '0; m_a2 = '0; m_b2 = '0; end
        else if (ce_mid) begin m_ad = m_a1[24:0] + m_d; m_a2 = m_a1; m_b2 = m_b1; end
        if (rst_c) m_c = '0; else if (ce_c) m_c = c;
        if (rst_in) begin m_a1 = '0; m_b1 = '0; m_d = '0; end
        else if (ce_in) begin m_a1 = a; m_b1 = b; m_d = d; end
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: p=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ce(input logic v);
        ce_in = v; ce_c = v; ce_mid = v; ce_m = v; ce_p = v;
    endtask

    task automatic set_rst(input logic v);
        rst_in = v; rst_c = v; rst_mid = v; rst_m = v; rst_p = v;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: p=%h expected %s", p, "completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        set_ce(1'b1);
        set_rst(1'b1);
        a = '0; b = '0; c = '0; d = '0; pcin = '0;
        opmode = '0; carry_sel = '0; carry_in = 1'b0;
        m_a1 = '0; m_a2 = '0; m_b1 = '0; m_b2 = '0; m_d = '0; m_ad = '0;
        m_c = '0; m_m = '0; m_ab = '0; m_p = '0;
        @(negedge clk);
        ticks(2);
        set_rst(1'b0);
        chk("R10 reset state", p, 48'd0);

        // R8: C through its own register, two edges to p
        c = 48'h1234_5678_9ABC;
        opmode = 7'b0001100;
        tick();
        chk("R8 C not yet at p", p, 48'd0);
        tick();
        chk("R8 C at p after two edges", p, 48'h1234_5678_9ABC);
        rst_c = 1'b1;
        tick();
        rst_c = 1'b0; ce_c = 1'b0;
        tick();
        chk("R10 C reset wins over enable", p, 48'd0);
        tick();
        chk("R9 C register held with enable low", p, 48'd0);
        ce_c = 1'b1; c = '0;

        // R1: four-edge latency, pre-adder plus signed multiply
        opmode = 7'b0000001;
        a = 30'd5; d = 25'd3; b = 18'h3FFF9;
        ticks(3);
        chk("R1 product not before fourth edge", p, 48'd0);
        tick();
        chk("R1 product at fourth edge", p, 48'hFFFF_FFFF_FFC8);

        // R2: pre-adder wraps at 25 bits
        a = 30'h0FF_FFFF; d = 25'd1; b = 18'd2;
        ticks(4);
        chk("R2 pre-adder wrap", p, 48'hFFFF_FE00_0000);

        // R3: {A,B} concatenation
        opmode = 7'b0000011;
        a = 30'h1234_5678; b = 18'h2_ABCD; d = 25'd0;
        ticks(4);
        chk("R3 concatenated A:B", p, {30'h1234_5678, 18'h2_ABCD});

        // R4 and R11: all-ones, opcode acts on the same edge
        opmode = 7'b0001000;
        tick();
        chk("R4 R11 all-ones operand", p, 48'hFFFF_FFFF_FFFF);

        // R5: shifted cascade, shifted P, plain cascade
        opmode = 7'b1000000; pcin = 48'h8000_0000_0000;
        tick();
        chk("R5 pcin shifted right 17", p, 48'hFFFF_C000_0000);
        opmode = 7'b1010000;
        tick();
        chk("R5 P shifted right 17", p, 48'hFFFF_FFFF_E000);
        opmode = 7'b0010000; pcin = 48'h0123_4567_89AB;
        tick();
        chk("R5 pcin passthrough", p, 48'h0123_4567_89AB);

        // R10 then R7 accumulate with the port carry
        rst_p = 1'b1;
        tick();
        chk("R10 P reset", p, 48'd0);
        rst_p = 1'b0;
        opmode = 7'b0100000; carry_sel = 3'd0; carry_in = 1'b1;
        ticks(3);
        chk("R7 accumulate carry", p, 48'd3);

        // R6: carry sources
        opmode = 7'b0001000; carry_in = 1'b0;
        tick();
        opmode = 7'b0100000; carry_sel = 3'd1;
        tick();
        chk("R6 P sign carry", p, 48'd0);
        carry_sel = 3'd2;
        tick();
        chk("R6 inverted P sign carry", p, 48'd1);
        carry_sel = 3'd3;
        tick();
        chk("R6 product sign carry", p, 48'd2);
        carry_sel = 3'd4;
        tick();
        chk("R6 inverted product sign carry", p, 48'd2);
        carry_sel = 3'd5; carry_in = 1'b1;
        tick();
        chk("R6 reserved carry code", p, 48'd2);

        // R9 hold, R10 reset priority
        carry_sel = 3'd0; carry_in = 1'b0;
        ce_p = 1'b0; opmode = 7'b0001000;
        ticks(2);
        chk("R9 P held with enable low", p, 48'd2);
        ce_p = 1'b1; rst_p = 1'b1;
        tick();
        chk("R10 reset wins over enable", p, 48'd0);
        rst_p = 1'b0;

        // R12: random enables, resets, data and opcodes against the model
        for (int i = 0; i < 4000; i++) begin
            a         = 30'($urandom);
            b         = 18'($urandom);
            c         = {16'($urandom), 32'($urandom)};
            d         = 25'($urandom);
            pcin      = {16'($urandom), 32'($urandom)};
            opmode    = 7'($urandom);
            carry_sel = 3'($urandom);
            carry_in  = 1'($urandom);
            ce_in  = ($urandom_range(0, 7) != 0);
            ce_c   = ($urandom_range(0, 7) != 0);
            ce_mid = ($urandom_range(0, 7) != 0);
            ce_m   = ($urandom_range(0, 7) != 0);
            ce_p   = ($urandom_range(0, 7) != 0);
            rst_in  = ($urandom_range(0, 63) == 0);
            rst_c   = ($urandom_range(0, 63) == 0);
            rst_mid = ($urandom_range(0, 63) == 0);
            rst_m   = ($urandom_range(0, 63) == 0);
            rst_p   = ($urandom_range(0, 63) == 0);
            tick();
            chk("R12 random model match", p, m_p);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule